// File: doc/BRIEF.md
# Interrupt Destination Mask Calculator

This block resolves the destination of one interrupt request into the set of processors that should receive it. A request carries a 32-bit destination value, a flag that picks logical or physical addressing, and a flag saying whether the destination uses the wide (extended) format or the short 8-bit format. Each of up to `NCPU` processors supplies an active bit, its ID, its logical destination register, a 4-bit destination-format code and its own extended-mode bit. The block returns an `NCPU`-bit mask with one bit set for each processor that the request targets.

Broadcast, physical ID match, the flat bitmask model and two cluster encodings are supported. A processor in extended mode ignores the logical register supplied for it and uses one derived from its ID. Arbitration among the matching processors and the delivery of the interrupt belong to other logic. The result is registered, so a request presented in one cycle yields its mask in the next.

Top module: `intr_target_mask`

## Requirements
- R1: A request sampled with `req_valid` high at a rising clock edge produces `out_valid` high and its mask after that same edge; when `out_valid` is low, `out_mask` is all zeros, and both are zero after reset.
- R2: A destination of all ones selects every active processor in both physical and logical addressing; all ones means `0xFF` in the low 8 bits for a short-format request and `0xFFFFFFFF` for an extended-format request.
- R3: In physical addressing a short-format request selects the processors whose ID bits 7:0 equal destination bits 7:0; an extended-format request compares all 32 bits of the ID.
- R4: In logical addressing, a processor whose format code is `4'hF` (flat) is selected when destination bits 7:0 and its logical register bits 31:24 share at least one set bit.
- R5: A processor with format code `4'h0` (cluster) in short mode has cluster number = logical register bits 31:28 and member bits = bits 27:24; a short-format request gives cluster = destination bits 7:4 and members = bits 3:0; the processor is selected when the clusters are equal and the member masks overlap.
- R6: In the same cluster code, an extended-mode processor takes cluster = logical register bits 31:16 and members = bits 15:0, and an extended-format request takes cluster = destination bits 31:16 and members = bits 15:0.
- R7: An extended-mode processor ignores its `cpu_ldr` input and uses a logical register of `(1 << id[3:0]) | (id[19:4] << 16)`.
- R8: A processor whose format code is neither `4'hF` nor `4'h0` is never selected by a logical, non-broadcast request.
- R9: A processor whose active bit is low is never selected, in any addressing mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_dest | input | 32 | Destination value |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_ext | input | 1 | 1 = extended 32-bit destination format |
| cpu_active | input | NCPU | Per-processor active bit |
| cpu_id | input | NCPU*32 | Per-processor ID, processor i in bits 32*i+31 : 32*i |
| cpu_ldr | input | NCPU*32 | Per-processor logical destination register |
| cpu_fmt | input | NCPU*4 | Per-processor format code, processor i in bits 4*i+3 : 4*i |
| cpu_ext | input | NCPU | Per-processor extended-mode bit |
| out_valid | output | 1 | Mask valid |
| out_mask | output | NCPU | Selected processors, bit i = processor i |

## Verification
Every result is due exactly one rising edge after its request is sampled, because the only register on the path is the output stage. The driver applies a request on a falling edge and queues its expected mask; the monitor looks one time step after each rising edge, where the request applied half a cycle earlier must now appear, so a missing, late or spurious `out_valid` is reported as well as a wrong mask. Processor configurations change only between requests on the falling edge, so the mask that is checked always belongs to one known configuration.

// File: rtl/idm_pkg.sv
package idm_pkg;

  localparam int DEST_W  = 32;
  localparam int FMT_W   = 4;
  localparam int SHORT_W = 8;
  localparam int HALF_W  = DEST_W / 2;

  localparam logic [FMT_W-1:0] FMT_CODE_FLAT    = 4'hF;
  localparam logic [FMT_W-1:0] FMT_CODE_CLUSTER = 4'h0;

  typedef enum logic [1:0] {
    MODEL_FLAT,
    MODEL_CLUSTER,
    MODEL_BAD
  } model_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              logical;
    logic              ext;
    logic              bcast;
  } req_t;

  function automatic model_e decode_model(input logic [FMT_W-1:0] code);
    if (code == FMT_CODE_FLAT)         return MODEL_FLAT;
    else if (code == FMT_CODE_CLUSTER) return MODEL_CLUSTER;
    else                               return MODEL_BAD;
  endfunction

endpackage

// File: rtl/idm_ldr_src.sv
module idm_ldr_src
  import idm_pkg::*;
(
  input  logic              cpu_ext,
  input  logic [DEST_W-1:0] cpu_id,
  input  logic [DEST_W-1:0] cpu_ldr,
  output logic [DEST_W-1:0] eff_ldr
);

  logic [HALF_W-1:0] member_onehot;
  logic [DEST_W-1:0] derived;

  always_comb begin
    member_onehot = '0;
    member_onehot[cpu_id[3:0]] = 1'b1;
    derived = {cpu_id[19:4], member_onehot};
    eff_ldr = cpu_ext ? derived : cpu_ldr;
  end

endmodule

// File: rtl/idm_lane.sv
module idm_lane
  import idm_pkg::*;
(
  input  req_t              req,
  input  logic              active,
  input  logic [DEST_W-1:0] id,
  input  logic [DEST_W-1:0] eff_ldr,
  input  logic [FMT_W-1:0]  fmt,
  input  logic              cpu_ext,
  output logic              hit
);

  model_e            model;
  logic              phys_hit;
  logic              flat_hit;
  logic              clus_hit;
  logic              log_hit;
  logic [HALF_W-1:0] req_cl, req_mem, cpu_cl, cpu_mem;

  always_comb begin
    model    = decode_model(fmt);
    phys_hit = req.ext ? (id == req.dest)
                       : (id[SHORT_W-1:0] == req.dest[SHORT_W-1:0]);
    flat_hit = |(req.dest[SHORT_W-1:0] & eff_ldr[DEST_W-1 -: SHORT_W]);

    req_cl  = req.ext ? req.dest[DEST_W-1:HALF_W] : {12'b0, req.dest[7:4]};
    req_mem = req.ext ? req.dest[HALF_W-1:0]      : {12'b0, req.dest[3:0]};
    cpu_cl  = cpu_ext ? eff_ldr[DEST_W-1:HALF_W]  : {12'b0, eff_ldr[31:28]};
    cpu_mem = cpu_ext ? eff_ldr[HALF_W-1:0]       : {12'b0, eff_ldr[27:24]};
    clus_hit = (req_cl == cpu_cl) && (|(req_mem & cpu_mem));

    unique case (model)
      MODEL_FLAT:    log_hit = flat_hit;
      MODEL_CLUSTER: log_hit = clus_hit;
      default:       log_hit = 1'b0;
    endcase

    hit = active && (req.bcast || (req.logical ? log_hit : phys_hit));
  end

  always_comb begin
    if (req.logical && !req.bcast && (fmt != FMT_CODE_FLAT) && (fmt != FMT_CODE_CLUSTER))
      AST_BAD_FMT_NO_HIT: assert (!hit); // R8
  end

endmodule

// File: rtl/intr_target_mask.sv
module intr_target_mask
  import idm_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [DEST_W-1:0]      req_dest,
  input  logic                   req_logical,
  input  logic                   req_ext,
  input  logic [NCPU-1:0]        cpu_active,
  input  logic [NCPU*DEST_W-1:0] cpu_id,
  input  logic [NCPU*DEST_W-1:0] cpu_ldr,
  input  logic [NCPU*FMT_W-1:0]  cpu_fmt,
  input  logic [NCPU-1:0]        cpu_ext,
  output logic                   out_valid,
  output logic [NCPU-1:0]        out_mask
);

  req_t            req;
  logic [NCPU-1:0] hits;

  always_comb begin
    req.dest    = req_dest;
    req.logical = req_logical;
    req.ext     = req_ext;
    req.bcast   = req_ext ? (req_dest == {DEST_W{1'b1}})
                          : (req_dest[SHORT_W-1:0] == {SHORT_W{1'b1}});
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic [DEST_W-1:0] eff_ldr;

    idm_ldr_src u_ldr (
      .cpu_ext (cpu_ext[g]),
      .cpu_id  (cpu_id[g*DEST_W +: DEST_W]),
      .cpu_ldr (cpu_ldr[g*DEST_W +: DEST_W]),
      .eff_ldr (eff_ldr)
    );

    idm_lane u_lane (
      .req     (req),
      .active  (cpu_active[g]),
      .id      (cpu_id[g*DEST_W +: DEST_W]),
      .eff_ldr (eff_ldr),
      .fmt     (cpu_fmt[g*FMT_W +: FMT_W]),
      .cpu_ext (cpu_ext[g]),
      .hit     (hits[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= req_valid;
      out_mask  <= req_valid ? hits : '0;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_mask == '0)); // R1
  AST_INACTIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ((out_mask & ~$past(cpu_active)) == '0)); // R9
  AST_BCAST_ALL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req.bcast) |=> (out_mask == $past(cpu_active))); // R2

endmodule

// File: tb/sim_intr_target_mask.sv
`timescale 1ns/1ps
module sim_intr_target_mask;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [31:0]   req_dest = '0;
  logic          req_logical = 1'b0;
  logic          req_ext = 1'b0;
  logic [N-1:0]  cpu_active = '0;
  logic [N*32-1:0] cpu_id = '0;
  logic [N*32-1:0] cpu_ldr = '0;
  logic [N*4-1:0]  cpu_fmt = '0;
  logic [N-1:0]  cpu_ext = '0;
  logic          out_valid;
  logic [N-1:0]  out_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [N-1:0] q_mask[$];
  string        q_tag[$];

  always #2.5 clk = ~clk;

  intr_target_mask #(.NCPU(N)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_ext(req_ext), .cpu_active(cpu_active),
    .cpu_id(cpu_id), .cpu_ldr(cpu_ldr), .cpu_fmt(cpu_fmt), .cpu_ext(cpu_ext),
    .out_valid(out_valid), .out_mask(out_mask)
  );

  task automatic set_cpu(input int i, input logic [31:0] id, input logic [31:0] ldr,
                         input logic [3:0] fmt, input logic ext, input logic act);
    cpu_id[i*32 +: 32]  = id;
    cpu_ldr[i*32 +: 32] = ldr;
    cpu_fmt[i*4 +: 4]   = fmt;
    cpu_ext[i]          = ext;
    cpu_active[i]       = act;
  endtask

  task automatic drive(input logic [31:0] d, input logic lg, input logic ex,
                       input logic [N-1:0] exp, input string tag);
    req_valid   = 1'b1;
    req_dest    = d;
    req_logical = lg;
    req_ext     = ex;
    q_mask.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: the result of a request applied on a falling edge is due
  // right after the following rising edge
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (q_mask.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected out_valid: actual mask %b expected no result", out_mask);
        end else begin
          logic [N-1:0] e;
          string t;
          e = q_mask.pop_front();
          t = q_tag.pop_front();
          if (out_mask !== e) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", t, out_mask, e);
          end
        end
      end else begin
        if (q_mask.size() != 0) begin
          checks++;
          fails++;
          $display("FAIL R1 result missing: actual out_valid 0 expected 1");
          void'(q_mask.pop_front());
          void'(q_tag.pop_front());
        end
        if (out_mask !== '0) begin
          checks++;
          fails++;
          $display("FAIL R1 idle mask: actual %b expected 0000", out_mask);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_mask !== '0) begin
      fails++;
      $display("FAIL R1 reset state: actual %b/%b expected 0/0000", out_valid, out_mask);
    end

    // short mode, flat, one-hot logical IDs
    set_cpu(0, 32'h0, 32'h0100_0000, 4'hF, 1'b0, 1'b1);
    set_cpu(1, 32'h1, 32'h0200_0000, 4'hF, 1'b0, 1'b1);
    set_cpu(2, 32'h2, 32'h0400_0000, 4'hF, 1'b0, 1'b1);
    set_cpu(3, 32'h3, 32'h0800_0000, 4'hF, 1'b0, 1'b1);
    drive(32'hFF, 1'b0, 1'b0, 4'b1111, "R2 phys broadcast");
    cpu_active[3] = 1'b0;
    drive(32'hFF, 1'b1, 1'b0, 4'b0111, "R2 R9 logical broadcast, cpu3 inactive");
    cpu_active[3] = 1'b1;
    drive(32'h02, 1'b0, 1'b0, 4'b0100, "R3 phys id 2");
    drive(32'h102, 1'b0, 1'b0, 4'b0100, "R3 short compares low 8 bits");
    drive(32'h102, 1'b0, 1'b1, 4'b0000, "R3 extended compares 32 bits");
    drive(32'h05, 1'b1, 1'b0, 4'b0101, "R4 flat mask 0x05");
    cpu_active[2] = 1'b0;
    drive(32'h05, 1'b1, 1'b0, 4'b0001, "R9 flat, cpu2 inactive");
    drive(32'h02, 1'b0, 1'b0, 4'b0000, "R9 phys id 2 inactive");
    cpu_active[2] = 1'b1;
    cpu_fmt[3:0] = 4'h5;
    drive(32'h05, 1'b1, 1'b0, 4'b0100, "R8 bad format cpu0");

    // short cluster
    set_cpu(0, 32'h0, 32'h1100_0000, 4'h0, 1'b0, 1'b1);
    set_cpu(1, 32'h1, 32'h1200_0000, 4'h0, 1'b0, 1'b1);
    set_cpu(2, 32'h2, 32'h2100_0000, 4'h0, 1'b0, 1'b1);
    set_cpu(3, 32'h3, 32'h1400_0000, 4'h0, 1'b0, 1'b1);
    drive(32'h13, 1'b1, 1'b0, 4'b0011, "R5 cluster 1 members 0011");
    drive(32'h21, 1'b1, 1'b0, 4'b0100, "R5 cluster 2 member 0001");
    drive(32'h14, 1'b1, 1'b0, 4'b1000, "R5 cluster 1 member 0100");
    drive(32'h31, 1'b1, 1'b0, 4'b0000, "R5 cluster 3 empty");

    // extended cluster, cpu_ldr inputs are garbage and must be ignored
    set_cpu(0, 32'h00, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1);
    set_cpu(1, 32'h01, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1);
    set_cpu(2, 32'h10, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1);
    set_cpu(3, 32'h13, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1);
    drive(32'h0000_0003, 1'b1, 1'b1, 4'b0011, "R6 R7 ext cluster 0");
    drive(32'h0001_0009, 1'b1, 1'b1, 4'b1100, "R6 R7 ext cluster 1");
    drive(32'h0001_0002, 1'b1, 1'b1, 4'b0000, "R6 R7 ext no member");
    drive(32'h0000_00FF, 1'b1, 1'b1, 4'b0011, "R2 0xFF not broadcast in ext");
    drive(32'hFFFF_FFFF, 1'b1, 1'b1, 4'b1111, "R2 ext broadcast");
    drive(32'h0000_0013, 1'b0, 1'b1, 4'b1000, "R3 ext phys id 0x13");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule